// File: doc/BRIEF.md
# Not-Recently-Used Victim Frame Selector

This block tracks two status flags for each of a fixed set of resident memory frames: a "referenced" flag and a "modified" flag. Every memory access names a frame and says whether it is a write. The referenced flag of that frame is set on any access, and the modified flag is set on a write. A periodic sweep pulse clears every referenced flag so that "recently used" means "used since the last sweep".

When the fault handler needs a frame to evict, it raises a request. The block places every frame in one of four classes by its flag pair and takes the victim from the best class that has any member. Within that class the pick is pseudo-random: a free-running shift register supplies a start index, and a wrapping upward scan from that index takes the first member of the class. One cycle later the block returns the frame index and that frame's modified flag, which tells the caller whether a write-back is due. At the same time it marks the chosen frame as a freshly loaded page that is being referenced.

Top module: `nru_victim_sel`

## Requirements
- R1: While reset is asserted, all referenced and modified flags are 0, `vic_valid` is 0, `vic_frame` and `vic_dirty` are 0, and the shift register holds 8'h01.
- R2: An access (`acc_valid` high) sets the referenced flag of frame `acc_frame`. It also sets that frame's modified flag when `acc_write` is 1 and leaves the modified flag unchanged when `acc_write` is 0.
- R3: A `clr_ref` pulse clears every referenced flag and leaves every modified flag unchanged. A frame accessed in the same cycle keeps its referenced flag at 1.
- R4: A frame's class is the 2-bit value {referenced, modified}. The victim is taken from the numerically lowest class that has at least one frame, so 00 is preferred over 01, 01 over 10, and 10 over 11.
- R5: Within the chosen class, the victim is the first member met when scanning frame indices upward from the start index, wrapping from NUM_FRAMES-1 to 0. The start index is the low log2(NUM_FRAMES) bits of the shift register value held in the request cycle.
- R6: The shift register advances on every clock edge out of reset, with next = {q[6:0], q[7]^q[5]^q[4]^q[3]}.
- R7: `vic_valid` is high in the cycle after `vic_req` is high and low in every other cycle. In that cycle `vic_frame` gives the victim and `vic_dirty` gives the modified flag the victim had in the request cycle.
- R8: On the edge that registers a victim, the victim's referenced flag becomes 1 and its modified flag becomes 0. This overrides a same-cycle `clr_ref`. If a write access hits the victim in the same cycle, its modified flag becomes 1 instead.
- R9: `vic_frame` and `vic_dirty` hold their last values while `vic_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Memory access event this cycle |
| acc_frame | input | 3 | Frame index of the access |
| acc_write | input | 1 | Access is a write |
| clr_ref | input | 1 | Clear all referenced flags |
| vic_req | input | 1 | Request a victim frame |
| vic_valid | output | 1 | Victim result present this cycle |
| vic_frame | output | 3 | Selected victim frame index |
| vic_dirty | output | 1 | Victim needs write-back before reuse |

## Verification
The checker takes for granted that `acc_frame` always names an existing frame and that reset is held for at least one edge before use. With the default power-of-two frame count every 3-bit index is legal, so the stimulus satisfies the first point by construction. Its class and dirty checks compare the registered result against a one-cycle-delayed copy of the flag state, so they do not depend on how requests, accesses and clears overlap, and the bench freely mixes all three in the same cycle, including back-to-back requests. The bench models the shift register from its stated recurrence and predicts every victim, sweeping many flag patterns built by random accesses and periodic clears.

// File: rtl/nru_pkg.sv
package nru_pkg;
   // Flag class: {referenced, modified}; lower value is a better victim
   typedef logic [1:0] nru_class_t;
   localparam int unsigned NUM_CLASSES = 4;

   function automatic nru_class_t class_of(input logic ref_f, input logic mod_f);
      return {ref_f, mod_f};
   endfunction
endpackage

// File: rtl/nru_lfsr.sv
module nru_lfsr #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [WIDTH-1:0] q
);
   logic fb;

   generate
      if (WIDTH == 8) begin : g_w8
         assign fb = q[7] ^ q[5] ^ q[4] ^ q[3];
      end else if (WIDTH == 16) begin : g_w16
         assign fb = q[15] ^ q[14] ^ q[12] ^ q[3];
      end else begin : g_bad
         $error("nru_lfsr: WIDTH must be 8 or 16");
         assign fb = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= {{(WIDTH-1){1'b0}}, 1'b1};
      else        q <= {q[WIDTH-2:0], fb};
   end
endmodule

// File: rtl/nru_flag_bank.sv
module nru_flag_bank #(
   parameter int unsigned NUM_FRAMES = 8,
   localparam int unsigned IDX_W = $clog2(NUM_FRAMES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_valid,
   input  logic [IDX_W-1:0]      acc_frame,
   input  logic                  acc_write,
   input  logic                  clr_ref,
   input  logic                  rpl_valid,
   input  logic [IDX_W-1:0]      rpl_frame,
   output logic [NUM_FRAMES-1:0] ref_q,
   output logic [NUM_FRAMES-1:0] mod_q
);
   generate
      for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
         logic hit, wr_hit, rpl;
         assign hit    = acc_valid && (acc_frame == IDX_W'(f));
         assign wr_hit = hit && acc_write;
         assign rpl    = rpl_valid && (rpl_frame == IDX_W'(f));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ref_q[f] <= 1'b0;
               mod_q[f] <= 1'b0;
            end else begin
               if (rpl || hit)  ref_q[f] <= 1'b1;
               else if (clr_ref) ref_q[f] <= 1'b0;

               if (rpl)         mod_q[f] <= wr_hit;
               else if (wr_hit) mod_q[f] <= 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/nru_pick.sv
module nru_pick
   import nru_pkg::*;
#(
   parameter int unsigned NUM_FRAMES = 8,
   localparam int unsigned IDX_W = $clog2(NUM_FRAMES)
) (
   input  logic [NUM_FRAMES-1:0] ref_q,
   input  logic [NUM_FRAMES-1:0] mod_q,
   input  logic [IDX_W-1:0]      start,
   output logic [IDX_W-1:0]      pick_frame,
   output logic                  pick_dirty
);
   logic [NUM_FRAMES-1:0] member [NUM_CLASSES];
   logic [NUM_FRAMES-1:0] win_mask;

   generate
      for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
         for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_f
            assign member[c][f] = (class_of(ref_q[f], mod_q[f]) == nru_class_t'(c));
         end
      end
   endgenerate

   // lowest non-empty class wins
   always_comb begin
      win_mask = '0;
      for (int c = NUM_CLASSES - 1; c >= 0; c--) begin
         if (|member[c]) win_mask = member[c];
      end
   end

   // rotating scan from the random start index
   always_comb begin
      logic found;
      logic [IDX_W-1:0] idx;
      found      = 1'b0;
      pick_frame = start;
      for (int k = 0; k < NUM_FRAMES; k++) begin
         idx = start + IDX_W'(k);
         if (!found && win_mask[idx]) begin
            found      = 1'b1;
            pick_frame = idx;
         end
      end
      pick_dirty = mod_q[pick_frame];
   end
endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel #(
   parameter int unsigned NUM_FRAMES = 8,
   parameter int unsigned LFSR_W     = 8,
   localparam int unsigned IDX_W     = $clog2(NUM_FRAMES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic [IDX_W-1:0] acc_frame,
   input  logic             acc_write,
   input  logic             clr_ref,
   input  logic             vic_req,
   output logic             vic_valid,
   output logic [IDX_W-1:0] vic_frame,
   output logic             vic_dirty
);
   generate
      if (NUM_FRAMES < 2 || (NUM_FRAMES & (NUM_FRAMES - 1)) != 0) begin : g_chk_frames
         $error("nru_victim_sel: NUM_FRAMES must be a power of two, at least 2");
      end
      if (LFSR_W < IDX_W) begin : g_chk_lfsr
         $error("nru_victim_sel: LFSR_W must cover the frame index");
      end
   endgenerate

   logic [LFSR_W-1:0]     lfsr_q;
   logic [NUM_FRAMES-1:0] ref_q, mod_q;
   logic [IDX_W-1:0]      pick_frame;
   logic                  pick_dirty;

   nru_lfsr #(.WIDTH(LFSR_W)) lfsr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .q     (lfsr_q)
   );

   nru_flag_bank #(.NUM_FRAMES(NUM_FRAMES)) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (acc_valid),
      .acc_frame (acc_frame),
      .acc_write (acc_write),
      .clr_ref   (clr_ref),
      .rpl_valid (vic_req),
      .rpl_frame (pick_frame),
      .ref_q     (ref_q),
      .mod_q     (mod_q)
   );

   nru_pick #(.NUM_FRAMES(NUM_FRAMES)) pick_i (
      .ref_q      (ref_q),
      .mod_q      (mod_q),
      .start      (lfsr_q[IDX_W-1:0]),
      .pick_frame (pick_frame),
      .pick_dirty (pick_dirty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vic_valid <= 1'b0;
         vic_frame <= '0;
         vic_dirty <= 1'b0;
      end else begin
         vic_valid <= vic_req;
         if (vic_req) begin
            vic_frame <= pick_frame;
            vic_dirty <= pick_dirty;
         end
      end
   end
endmodule

// File: rtl/nru_victim_sel_chk.sv
module nru_victim_sel_chk #(
   parameter int unsigned NUM_FRAMES = 8,
   parameter int unsigned LFSR_W     = 8,
   localparam int unsigned IDX_W     = $clog2(NUM_FRAMES)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  acc_valid,
   input logic [IDX_W-1:0]      acc_frame,
   input logic                  acc_write,
   input logic                  clr_ref,
   input logic                  vic_req,
   input logic                  vic_valid,
   input logic [IDX_W-1:0]      vic_frame,
   input logic                  vic_dirty,
   input logic [NUM_FRAMES-1:0] ref_bits,
   input logic [NUM_FRAMES-1:0] mod_bits,
   input logic [LFSR_W-1:0]     lfsr
);
   logic [NUM_FRAMES-1:0] ref_prev, mod_prev;
   logic                  lower_exists;

   always_ff @(posedge clk) begin
      ref_prev <= ref_bits;
      mod_prev <= mod_bits;
   end

   always_comb begin
      lower_exists = 1'b0;
      for (int f = 0; f < NUM_FRAMES; f++) begin
         if ({ref_prev[f], mod_prev[f]} < {ref_prev[vic_frame], mod_prev[vic_frame]})
            lower_exists = 1'b1;
      end
   end

   a_r7_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      vic_req |=> vic_valid);
   a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !vic_req |=> !vic_valid);
   a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
      !vic_req |=> ($stable(vic_frame) && $stable(vic_dirty)));
   a_r2_access_sets_ref: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> ref_bits[$past(acc_frame)]);
   a_r2_write_sets_mod: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write) |=> mod_bits[$past(acc_frame)]);
   a_r3_clear_refs: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ref && !acc_valid && !vic_req) |=> (ref_bits == '0));
   a_r3_clear_keeps_mod: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ref && !acc_valid && !vic_req) |=> $stable(mod_bits));
   a_r4_lowest_class: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid |-> !lower_exists);
   a_r7_dirty_matches: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid |-> (vic_dirty == mod_prev[vic_frame]));
   a_r8_victim_referenced: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid |-> ref_bits[vic_frame]);
   a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr != '0);
endmodule

bind nru_victim_sel nru_victim_sel_chk #(.NUM_FRAMES(NUM_FRAMES), .LFSR_W(LFSR_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_frame (acc_frame),
   .acc_write (acc_write),
   .clr_ref   (clr_ref),
   .vic_req   (vic_req),
   .vic_valid (vic_valid),
   .vic_frame (vic_frame),
   .vic_dirty (vic_dirty),
   .ref_bits  (ref_q),
   .mod_bits  (mod_q),
   .lfsr      (lfsr_q)
);

// File: tb/nru_victim_sel_tb_top.sv
module nru_victim_sel_tb_top;
   localparam int NF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0;
   logic [2:0] acc_frame = '0;
   logic       acc_write = 1'b0;
   logic       clr_ref = 1'b0;
   logic       vic_req = 1'b0;
   logic       vic_valid;
   logic [2:0] vic_frame;
   logic       vic_dirty;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model, built from the requirements
   logic [NF-1:0] m_ref = '0, m_mod = '0;
   logic [7:0]    m_lfsr = 8'h01;
   logic          e_valid = 1'b0;
   logic [2:0]    e_frame = '0;
   logic          e_dirty = 1'b0;
   string         phase = "R1 reset";

   always #10 clk = ~clk;   // 50 MHz

   nru_victim_sel dut_i (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
      .acc_write(acc_write), .clr_ref(clr_ref), .vic_req(vic_req),
      .vic_valid(vic_valid), .vic_frame(vic_frame), .vic_dirty(vic_dirty)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s [%s]: actual=%0d expected=%0d", req, phase, act, exp);
      end
   endtask

   // R4/R5 expected victim: lowest class, first member from start upward
   function automatic logic [2:0] model_pick(input logic [2:0] start);
      for (int c = 0; c < 4; c++) begin
         for (int k = 0; k < NF; k++) begin
            logic [2:0] idx;
            idx = start + 3'(k);
            if ({m_ref[idx], m_mod[idx]} == 2'(c)) return idx;
         end
      end
      return start;
   endfunction

   // one cycle: check outputs, drive stimulus, advance the model (called at negedge)
   task automatic step(input bit av, input logic [2:0] af, input bit aw,
                       input bit cl, input bit rq);
      logic [2:0] v;
      check("R7 valid", int'(vic_valid), int'(e_valid));
      check("R4/R5 frame (R9 hold)", int'(vic_frame), int'(e_frame));
      check("R7 dirty (R9 hold)", int'(vic_dirty), int'(e_dirty));
      v = model_pick(m_lfsr[2:0]);
      e_valid = rq;
      if (rq) begin
         e_frame = v;
         e_dirty = m_mod[v];
      end
      if (cl) m_ref = '0;                       // R3
      if (av) begin                             // R2
         m_ref[af] = 1'b1;
         if (aw) m_mod[af] = 1'b1;
      end
      if (rq) begin                             // R8
         m_ref[v] = 1'b1;
         m_mod[v] = av && aw && (af == v);
      end
      m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};  // R6
      acc_valid = av; acc_frame = af; acc_write = aw; clr_ref = cl; vic_req = rq;
      @(negedge clk);
   endtask

   task automatic idle();
      step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs at reset
      check("R1 valid", int'(vic_valid), 0);
      check("R1 frame", int'(vic_frame), 0);
      rst_n = 1'b1;
      m_lfsr = 8'h01;

      // R1/R5: all frames class 00, victim equals start index
      phase = "R1 clean";
      step(1'b0, 3'd0, 1'b0, 1'b0, 1'b1);
      idle();

      // R2: read every frame, then write two; class 10 should be chosen
      phase = "R2 access";
      for (int f = 0; f < NF; f++) step(1'b1, 3'(f), 1'b0, 1'b0, 1'b0);
      step(1'b1, 3'd2, 1'b1, 1'b0, 1'b0);
      step(1'b1, 3'd6, 1'b1, 1'b0, 1'b0);
      step(1'b0, 3'd0, 1'b0, 1'b0, 1'b1);
      idle();

      // R3: clear with a same-cycle access; class 01 frames come before 10
      phase = "R3 clear";
      step(1'b1, 3'd5, 1'b0, 1'b1, 1'b0);
      step(1'b0, 3'd0, 1'b0, 1'b0, 1'b1);
      step(1'b0, 3'd0, 1'b0, 1'b0, 1'b1);
      step(1'b0, 3'd0, 1'b0, 1'b0, 1'b1);
      idle();

      // R8: request with a clear and a write to any frame in the same cycle
      phase = "R8 overlap";
      for (int f = 0; f < NF; f++) step(1'b1, 3'(f), 1'b1, 1'b0, 1'b0);
      for (int k = 0; k < 6; k++) step(1'b1, 3'(k), 1'b1, 1'b1, 1'b1);
      step(1'b0, 3'd0, 1'b0, 1'b0, 1'b1);
      idle();

      // R4/R5/R6 sweep: random mixes over many flag patterns
      phase = "R4 sweep";
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = $urandom % 100;
         step(($urandom % 3) != 0, 3'($urandom), ($urandom % 4) == 0,
              r < 6, (r % 5) == 0);
      end
      idle();
      idle();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog [%s]: actual=%0d expected=%0d", phase, 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule